// File: doc/BRIEF.md
# Load/Store Lane and Alignment Unit

This unit sits between the register file of a 32-bit processor and a 32-bit memory bus. The core hands it one access at a time: an address, a size (byte, halfword or longword), a direction and a destination tag. The unit first checks that the address fits the size. A misaligned access never reaches memory; the core receives a one-cycle address error pulse instead.

An aligned access becomes a bus request. The request carries a 4-bit lane-enable mask and, for stores, the write data copied onto every lane the size can reach. The request is held until memory answers with a valid strobe. For loads, the unit picks the addressed lanes out of the returned word. It then sign-extends a byte or halfword to a full 32-bit value and hands the value back to the core one cycle later, together with the destination tag.

Lane order is big-endian unless the address falls in one of two regions whose little-endian enable is set. The region is taken from address bits 28:26. Region code 3'b010 has the first enable and region code 3'b100 has the second.

Top module: `ldst_unit`

## Requirements
- R1: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 longword, and 2'b11 is handled as a longword. A halfword at an odd address, or a longword whose address bits 1:0 are not zero, is misaligned. Such a request raises `addr_err` for exactly the one cycle after it is accepted. It asserts no `mem_req` and produces no `ld_valid`.
- R2: A byte access is legal at every address offset 0 to 3.
- R3: In big-endian order, the byte at address offset k occupies bus bits [31-8k -: 8]. A halfword at offset 0 occupies bits 31:16, and one at offset 2 occupies bits 15:0.
- R4: In little-endian order, the byte at address offset k occupies bus bits [8k +: 8]. A halfword at offset 0 occupies bits 15:0, and one at offset 2 occupies bits 31:16.
- R5: Little-endian order applies only when address bits 28:26 equal 3'b010 and `le_region_a_en` is 1, or equal 3'b100 and `le_region_b_en` is 1. Every other access is big-endian, whatever the enables are.
- R6: A loaded byte is sign-extended from its bit 7 and a loaded halfword from its bit 15, after lane selection. A longword is returned unchanged.
- R7: `mem_be` has a 1 on exactly the lanes the access covers, under the active order. A byte store copies its byte onto all four lanes, a halfword store copies its halfword onto both halves, and a longword store passes the data through unchanged.
- R8: An accepted aligned access raises `mem_req` in the next cycle. `mem_req`, `mem_addr`, `mem_be` and `mem_we` then stay constant until the cycle in which `mem_valid` is sampled high, and `mem_req` drops in the cycle after that.
- R9: A load returns `ld_valid` for one cycle, in the cycle after `mem_valid`, with `ld_tag` equal to the request's tag. A store never raises `ld_valid`.
- R10: `core_req` is ignored while `busy` is high. The outstanding access's address and tag are unaffected, and no second bus request follows.
- R11: After reset, `busy`, `addr_err`, `ld_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request, accepted while not busy |
| core_we | input | 1 | 1 store, 0 load |
| core_size | input | 2 | Access size code |
| core_addr | input | 32 | Byte address |
| core_wdata | input | 32 | Store data, right-aligned |
| core_tag | input | 4 | Destination register tag |
| le_region_a_en | input | 1 | Little-endian enable for region 3'b010 |
| le_region_b_en | input | 1 | Little-endian enable for region 3'b100 |
| busy | output | 1 | An access is outstanding on the bus |
| addr_err | output | 1 | Misalignment pulse |
| ld_valid | output | 1 | Load result valid |
| ld_tag | output | 4 | Tag of the returned load |
| ld_data | output | 32 | Extended load result |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Bus address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_valid | input | 1 | Memory completion strobe |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench loads a word whose bytes alternate in sign bit from every offset, in both orders. A design that swapped lanes, or that tested the sign bit before selecting the lane, returns a wrong value or wrong upper bits. It enables both little-endian controls while using addresses outside the two regions, and it uses each region with only the other region's enable set; a loose region decode shows up as flipped lanes. Misaligned halfwords and longwords, including a misaligned store, must leave the bus silent and return no result. A request made while busy must not disturb the outstanding address or tag. Memory latency is varied to confirm the request holds steady.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 2 * BYTE_W;
    localparam int unsigned LANES  = DATA_W / BYTE_W;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_LONG = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int unsigned            AREA_W = 3,
    parameter logic [AREA_W-1:0]      AREA_A = 3'b010,
    parameter logic [AREA_W-1:0]      AREA_B = 3'b100
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [AREA_W-1:0] area,
    input  size_e             size,
    input  logic              le_a,
    input  logic              le_b,
    output logic              misaligned,
    output logic              little,
    output logic [LANES-1:0]  lane_en
);
    logic [OFF_W:0] span;
    logic [OFF_W:0] first;
    logic [OFF_W:0] last_x;

    // Number of bytes the access covers.
    always_comb begin
        case (size)
            SZ_BYTE: span = (OFF_W+1)'(1);
            SZ_HALF: span = (OFF_W+1)'(2);
            default: span = (OFF_W+1)'(LANES);
        endcase
    end

    // Alignment rule: halfword needs offset bit 0 clear, longword all clear.
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = (off != '0);
        endcase
    end

    assign little = ((area == AREA_A) && le_a) || ((area == AREA_B) && le_b);
    assign first  = {1'b0, off};
    assign last_x = first + span;

    // Each lane holds a fixed address offset that depends on byte order.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W:0] BIG_POS = (OFF_W+1)'(LANES - 1 - i);
        localparam logic [OFF_W:0] LIT_POS = (OFF_W+1)'(i);
        logic [OFF_W:0] pos;
        assign pos        = little ? LIT_POS : BIG_POS;
        assign lane_en[i] = (pos >= first) && (pos < last_x);
    end
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
    import ldst_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  size_e             size,
    output logic [DATA_W-1:0] lanes
);
    for (genvar i = 0; i < LANES; i++) begin : g_copy
        localparam int unsigned HSRC = (i % (HALF_W / BYTE_W)) * BYTE_W;
        logic [BYTE_W-1:0] lane_v;
        always_comb begin
            case (size)
                SZ_BYTE: lane_v = wdata[BYTE_W-1:0];
                SZ_HALF: lane_v = wdata[HSRC +: BYTE_W];
                default: lane_v = wdata[i*BYTE_W +: BYTE_W];
            endcase
        end
        assign lanes[i*BYTE_W +: BYTE_W] = lane_v;
    end
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANES-1:0]  lane_en,
    input  size_e             size,
    output logic [DATA_W-1:0] value
);
    logic [LANES:0][BYTE_W-1:0] acc;
    logic [BYTE_W-1:0]          byte_v;
    logic [HALF_W-1:0]          half_v;

    // Byte pick: OR of the enabled lane (exactly one for a byte access).
    assign acc[0] = '0;
    for (genvar i = 0; i < LANES; i++) begin : g_pick
        assign acc[i+1] = acc[i] | (rdata[i*BYTE_W +: BYTE_W] & {BYTE_W{lane_en[i]}});
    end
    assign byte_v = acc[LANES];

    // Halfword pick: the upper half when the top lane is enabled.
    assign half_v = lane_en[LANES-1] ? rdata[DATA_W-1 -: HALF_W] : rdata[HALF_W-1:0];

    always_comb begin
        case (size)
            SZ_BYTE: value = {{(DATA_W-BYTE_W){byte_v[BYTE_W-1]}}, byte_v};
            SZ_HALF: value = {{(DATA_W-HALF_W){half_v[HALF_W-1]}}, half_v};
            default: value = rdata;
        endcase
    end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned AREA_LSB = 26,
    parameter int unsigned AREA_W   = 3,
    parameter logic [AREA_W-1:0] AREA_A = 3'b010,
    parameter logic [AREA_W-1:0] AREA_B = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [1:0]        core_size,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [TAG_W-1:0]  core_tag,
    input  logic              le_region_a_en,
    input  logic              le_region_b_en,
    output logic              busy,
    output logic              addr_err,
    output logic              ld_valid,
    output logic [TAG_W-1:0]  ld_tag,
    output logic [DATA_W-1:0] ld_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        phase_e            phase;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [LANES-1:0]  mbe;
        logic [DATA_W-1:0] mwdata;
        size_e             size;
        logic [TAG_W-1:0]  tag;
        logic              ldv;
        logic [TAG_W-1:0]  ldtag;
        logic [DATA_W-1:0] ldata;
        logic              aerr;
    } unit_st_t;

    unit_st_t st_d, st_q;

    size_e             req_size;
    logic              req_misal;
    logic              req_little;
    logic [LANES-1:0]  req_lanes;
    logic [DATA_W-1:0] req_wlanes;
    logic [DATA_W-1:0] load_val;

    assign req_size = size_e'(core_size);

    ldst_decode #(
        .AREA_W (AREA_W),
        .AREA_A (AREA_A),
        .AREA_B (AREA_B)
    ) u_decode (
        .off        (core_addr[OFF_W-1:0]),
        .area       (core_addr[AREA_LSB +: AREA_W]),
        .size       (req_size),
        .le_a       (le_region_a_en),
        .le_b       (le_region_b_en),
        .misaligned (req_misal),
        .little     (req_little),
        .lane_en    (req_lanes)
    );

    ldst_store_lanes u_store (
        .wdata (core_wdata),
        .size  (req_size),
        .lanes (req_wlanes)
    );

    ldst_load_extract u_load (
        .rdata   (mem_rdata),
        .lane_en (st_q.mbe),
        .size    (st_q.size),
        .value   (load_val)
    );

    // Byte order is folded into the lane mask; the flag itself is not kept.
    logic order_unused;
    assign order_unused = req_little;

    always_comb begin
        st_d      = st_q;
        st_d.ldv  = 1'b0;
        st_d.aerr = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (core_req) begin
                    if (req_misal) begin
                        st_d.aerr = 1'b1;
                    end else begin
                        st_d.phase  = PH_WAIT;
                        st_d.mreq   = 1'b1;
                        st_d.mwe    = core_we;
                        st_d.maddr  = core_addr;
                        st_d.mbe    = req_lanes;
                        st_d.mwdata = req_wlanes;
                        st_d.size   = req_size;
                        st_d.tag    = core_tag;
                    end
                end
            end
            PH_WAIT: begin
                if (mem_valid) begin
                    st_d.phase = PH_IDLE;
                    st_d.mreq  = 1'b0;
                    if (!st_q.mwe) begin
                        st_d.ldv   = 1'b1;
                        st_d.ldtag = st_q.tag;
                        st_d.ldata = load_val;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase == PH_WAIT);
    assign addr_err  = st_q.aerr;
    assign ld_valid  = st_q.ldv;
    assign ld_tag    = st_q.ldtag;
    assign ld_data   = st_q.ldata;
    assign mem_req   = st_q.mreq;
    assign mem_we    = st_q.mwe;
    assign mem_addr  = st_q.maddr;
    assign mem_be    = st_q.mbe;
    assign mem_wdata = st_q.mwdata;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
    import ldst_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              addr_err,
    input logic              ld_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic              mem_valid
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> !mem_req);

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!mem_req && !ld_valid));

    // R9
    ldv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_req && mem_valid && !mem_we));

    // R9
    ldv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R7
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (($countones(mem_be) == 1) || (mem_be == 4'b0011) ||
                     (mem_be == 4'b1100) || (mem_be == 4'b1111)));
endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ldst_unit.sv
module sim_ldst_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [1:0]  core_size = 2'b00;
    logic [31:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic [3:0]  core_tag = '0;
    logic        le_a = 1'b0;
    logic        le_b = 1'b0;
    logic        busy, addr_err, ld_valid, mem_req, mem_we;
    logic [3:0]  ld_tag, mem_be;
    logic [31:0] ld_data, mem_addr, mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ldst_unit u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_size(core_size), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_tag(core_tag), .le_region_a_en(le_a), .le_region_b_en(le_b),
        .busy(busy), .addr_err(addr_err), .ld_valid(ld_valid), .ld_tag(ld_tag),
        .ld_data(ld_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    function automatic bit is_little(logic [31:0] a);
        return ((a[28:26] == 3'b010) && le_a) || ((a[28:26] == 3'b100) && le_b);
    endfunction

    function automatic logic [3:0] exp_be(logic [31:0] a, logic [1:0] sz);
        bit lt = is_little(a);
        int off = int'(a[1:0]);
        if (sz == 2'b00) return 4'b0001 << (lt ? off : 3 - off);
        if (sz == 2'b01) return ((off == 0) != lt) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] a, logic [1:0] sz, logic [31:0] rd);
        bit lt = is_little(a);
        int off = int'(a[1:0]);
        logic [7:0]  b;
        logic [15:0] h;
        if (sz == 2'b00) begin
            b = rd[8*(lt ? off : 3 - off) +: 8];
            return {{24{b[7]}}, b};
        end
        if (sz == 2'b01) begin
            h = ((off == 0) != lt) ? rd[31:16] : rd[15:0];
            return {{16{h[15]}}, h};
        end
        return rd;
    endfunction

    function automatic logic [31:0] exp_store(logic [1:0] sz, logic [31:0] wd);
        if (sz == 2'b00) return {4{wd[7:0]}};
        if (sz == 2'b01) return {2{wd[15:0]}};
        return wd;
    endfunction

    task automatic issue(logic [31:0] a, logic [1:0] sz, logic we, logic [31:0] wd, logic [3:0] tag);
        @(negedge clk);
        core_req = 1'b1; core_addr = a; core_size = sz; core_we = we;
        core_wdata = wd; core_tag = tag;
        @(negedge clk);
        core_req = 1'b0;
    endtask

    task automatic run_load(string req, logic [31:0] a, logic [1:0] sz, logic [31:0] rd,
                            logic [3:0] tag, int lat);
        issue(a, sz, 1'b0, 32'h0, tag);
        chk("R8", "mem_req raised", 32'(mem_req), 32'd1);
        chk(req, "load lanes", 32'(mem_be), 32'(exp_be(a, sz)));
        chk("R8", "mem_addr", mem_addr, a);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk("R8", "mem_req held", {31'd0, mem_req}, 32'd1);
            chk("R8", "mem_addr held", mem_addr, a);
        end
        mem_valid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk("R9", "ld_valid", {31'd0, ld_valid}, 32'd1);
        chk("R9", "ld_tag", 32'(ld_tag), 32'(tag));
        chk(req, "ld_data", ld_data, exp_load(a, sz, rd));
        chk("R8", "mem_req dropped", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        chk("R9", "ld_valid one cycle", {31'd0, ld_valid}, 32'd0);
    endtask

    task automatic run_store(string req, logic [31:0] a, logic [1:0] sz, logic [31:0] wd);
        issue(a, sz, 1'b1, wd, 4'd9);
        chk("R7", "store mem_we", {31'd0, mem_we}, 32'd1);
        chk(req, "store lanes", 32'(mem_be), 32'(exp_be(a, sz)));
        chk("R7", "store data", mem_wdata, exp_store(sz, wd));
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R9", "store gives no ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R8", "busy cleared", {31'd0, busy}, 32'd0);
    endtask

    task automatic run_misaligned(logic [31:0] a, logic [1:0] sz, logic we);
        issue(a, sz, we, 32'h1111_2222, 4'd5);
        chk("R1", "addr_err", {31'd0, addr_err}, 32'd1);
        chk("R1", "no mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1", "not busy", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R1", "addr_err one cycle", {31'd0, addr_err}, 32'd0);
        chk("R1", "no ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R1", "still no mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic run_busy_ignore();
        issue(32'h0000_2000, 2'b10, 1'b0, 32'h0, 4'd3);
        core_req = 1'b1; core_addr = 32'h0000_3004; core_tag = 4'd7; core_size = 2'b10;
        @(negedge clk);
        core_req = 1'b0;
        chk("R10", "address kept", mem_addr, 32'h0000_2000);
        chk("R10", "still busy", {31'd0, busy}, 32'd1);
        mem_valid = 1'b1; mem_rdata = 32'hCAFE_0001;
        @(negedge clk);
        mem_valid = 1'b0;
        chk("R10", "tag kept", 32'(ld_tag), 32'd3);
        chk("R10", "data", ld_data, 32'hCAFE_0001);
        @(negedge clk);
        chk("R10", "no second request", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R11", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "addr_err after reset", {31'd0, addr_err}, 32'd0);
        chk("R11", "ld_valid after reset", {31'd0, ld_valid}, 32'd0);

        // R2 R3 R5: both enables set but region 000 stays big-endian
        le_a = 1'b1; le_b = 1'b1;
        for (int k = 0; k < 4; k++)
            run_load("R3", 32'h0000_1000 + 32'(k), 2'b00, 32'h8142_C314, 4'(k), k % 2);
        run_load("R5", 32'h1800_0001, 2'b00, 32'h8142_C314, 4'd1, 0);

        // R4 R2: little-endian in both regions
        for (int k = 0; k < 4; k++)
            run_load("R4", 32'h0800_0000 + 32'(k), 2'b00, 32'h8142_C314, 4'(k + 4), 0);
        run_load("R4", 32'h1000_0003, 2'b00, 32'h8142_C314, 4'd8, 1);

        // R6: halfword and longword, both orders
        run_load("R6", 32'h0000_0100, 2'b01, 32'h8001_7FFF, 4'd2, 0);
        run_load("R6", 32'h0000_0102, 2'b01, 32'h8001_7FFF, 4'd2, 0);
        run_load("R6", 32'h1000_0100, 2'b01, 32'h8001_7FFF, 4'd2, 0);
        run_load("R6", 32'h1000_0102, 2'b01, 32'h8001_7FFF, 4'd2, 3);
        run_load("R6", 32'h1000_0104, 2'b10, 32'h8001_7FFF, 4'd6, 0);
        run_load("R6", 32'h0000_0104, 2'b11, 32'hF00D_8000, 4'd6, 0);

        // R5: each region with only the other region's enable set
        le_a = 1'b0; le_b = 1'b1;
        run_load("R5", 32'h0800_0000, 2'b00, 32'h8142_C314, 4'd10, 0);
        le_a = 1'b1; le_b = 1'b0;
        run_load("R5", 32'h1000_0000, 2'b00, 32'h8142_C314, 4'd11, 0);
        run_load("R5", 32'h0800_0002, 2'b01, 32'h8001_7FFF, 4'd12, 0);

        // R7: stores
        le_a = 1'b1; le_b = 1'b1;
        run_store("R7", 32'h0000_0041, 2'b00, 32'h1234_56AB);
        run_store("R7", 32'h0800_0041, 2'b00, 32'h1234_56AB);
        run_store("R7", 32'h0000_0042, 2'b01, 32'h1234_56AB);
        run_store("R7", 32'h1000_0042, 2'b01, 32'h1234_56AB);
        run_store("R7", 32'h0000_0040, 2'b10, 32'h1234_56AB);

        // R1: misaligned accesses
        run_misaligned(32'h0000_0201, 2'b01, 1'b0);
        run_misaligned(32'h0000_0203, 2'b01, 1'b1);
        run_misaligned(32'h0000_0202, 2'b10, 1'b0);
        run_misaligned(32'h0000_0201, 2'b10, 1'b0);
        run_misaligned(32'h0000_0203, 2'b10, 1'b1);

        // R10
        run_busy_ignore();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule